// File: doc/BRIEF.md
# Multi-Size Address Translation Buffer

This block is a fully associative translation buffer that turns virtual addresses into physical addresses. Each of its 32 slots holds one mapping, and each mapping covers one of three region sizes: a 1 MB segment, an 8 KB large page or a 4 KB small page. Each slot keeps its own size code, so the number of compared tag bits and the number of offset bits copied from the virtual address differ from slot to slot. Each slot also stores a cacheable flag and a bufferable flag, and a hit returns both.

A lookup presents a virtual address with `lk_valid`. One clock later the block returns a hit flag, the physical address and the two attribute flags. A refill writes one new mapping into the slot named by a rotating victim pointer. Maintenance commands either wipe every slot or wipe only the slots whose region covers a given virtual address. The block accepts one command per cycle, and the commands have a fixed priority. The command decoder has four named states, selected again every cycle: `OP_NONE` (idle), `OP_FILL` (refill), `OP_FLUSH_ONE` (flush by address) and `OP_FLUSH_ALL` (flush everything). The transitions are taken by priority: a flush-all request enters `OP_FLUSH_ALL`, otherwise a flush-one request enters `OP_FLUSH_ONE`, otherwise a refill enters `OP_FILL`, and otherwise the decoder stays in `OP_NONE`. A lookup can fall in the same cycle as any command.

Top module: `xlate_buf`

## Requirements
- R1: After reset every slot is empty, the victim pointer is at slot 0, all response outputs are 0, and every lookup misses.
- R2: `rsp_valid` is high in exactly the cycle that follows a cycle with `lk_valid` high. A lookup's result appears on the response outputs in that following cycle.
- R3: `fill_size` and the stored size use this code: 2'b00 means unused, 2'b01 means 1 MB, 2'b10 means 8 KB and 2'b11 means 4 KB. A slot matches when virtual address bits [31:20] (1 MB), [31:13] (8 KB) or [31:12] (4 KB) equal the stored tag. A refill with code 2'b00 leaves an empty slot, and the pointer still advances.
- R4: On a hit, the physical address takes the stored frame in the compared bit positions. Bits [19:0], [12:0] or [11:0] (the offset for the slot's size) are copied unchanged from the lookup address. Offset bits of the refill addresses are ignored.
- R5: A hit returns the slot's cacheable and bufferable flags. A miss, or a cycle with no lookup, drives `rsp_paddr`, `rsp_cacheable` and `rsp_bufferable` to 0.
- R6: A refill writes the slot named by the victim pointer. The pointer then moves up by one and wraps from 31 to 0, so the 33rd refill after reset overwrites slot 0.
- R7: A flush-all command empties every slot.
- R8: A flush-one command empties every slot whose region (judged at its own size) contains `flush_vaddr` and leaves all other slots unchanged.
- R9: When several valid slots match a lookup, the result comes from the lowest-indexed one.
- R10: In one cycle only one command is taken. Flush-all beats flush-one, and flush-one beats refill. A command that loses is ignored; a refill that loses writes nothing and does not move the pointer.
- R11: A lookup in the same cycle as a command sees the slot contents from before that command takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| fill_en | input | 1 | Refill request |
| fill_vaddr | input | 32 | Refill virtual address (offset bits ignored) |
| fill_paddr | input | 32 | Refill physical address (offset bits ignored) |
| fill_size | input | 2 | Refill size code |
| fill_cacheable | input | 1 | Refill cacheable flag |
| fill_bufferable | input | 1 | Refill bufferable flag |
| flush_all | input | 1 | Empty all slots |
| flush_one | input | 1 | Empty slots covering `flush_vaddr` |
| flush_vaddr | input | 32 | Address for flush-one |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_cacheable | output | 1 | Cacheable flag of the hit slot |
| rsp_bufferable | output | 1 | Bufferable flag of the hit slot |

## Verification
A lookup can fall in the same cycle as a refill, a flush-one or a flush-all. The bench provokes each case by presenting an address together with a command that changes the slot covering that address. For example, it looks up a page in the same cycle as the refill that installs it, or in the same cycle as the flush that removes it. Each result is judged against a bench model that answers the lookup from the slot contents before the command and applies the command afterwards. The same-cycle result and the one from the following lookup must both agree with that order.

// File: rtl/xb_pkg.sv
package xb_pkg;
    localparam int ADDR_W  = 32;
    localparam int SEG_OFS = 20;
    localparam int LPG_OFS = 13;
    localparam int SPG_OFS = 12;

    typedef enum logic [1:0] {
        SZ_NONE  = 2'b00,
        SZ_SEG   = 2'b01,
        SZ_LARGE = 2'b10,
        SZ_SMALL = 2'b11
    } map_size_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_FILL,
        OP_FLUSH_ONE,
        OP_FLUSH_ALL
    } maint_op_e;

    typedef struct packed {
        map_size_e         size;
        logic [ADDR_W-1:0] tag;
        logic [ADDR_W-1:0] frame;
        logic              cacheable;
        logic              bufferable;
    } xb_entry_t;

    // Mask of the offset bits that pass through for a given region size.
    function automatic logic [ADDR_W-1:0] offset_mask(input map_size_e sz);
        logic [ADDR_W-1:0] m;
        unique case (sz)
            SZ_SEG:   m = (ADDR_W'(1) << SEG_OFS) - ADDR_W'(1);
            SZ_LARGE: m = (ADDR_W'(1) << LPG_OFS) - ADDR_W'(1);
            SZ_SMALL: m = (ADDR_W'(1) << SPG_OFS) - ADDR_W'(1);
            SZ_NONE:  m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/xb_slot.sv
module xb_slot
    import xb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  xb_entry_t         wr_data,
    input  logic              clr,
    input  logic [ADDR_W-1:0] probe_va,
    input  logic [ADDR_W-1:0] flush_va,
    output xb_entry_t         slot,
    output logic              probe_hit,
    output logic              flush_hit
);
    logic [ADDR_W-1:0] keep;
    logic              live;

    assign keep      = ~offset_mask(slot.size);
    assign live      = (slot.size != SZ_NONE);
    assign probe_hit = live && ((probe_va & keep) == slot.tag);
    assign flush_hit = live && ((flush_va & keep) == slot.tag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (clr) begin
            slot.size <= SZ_NONE;
        end else if (wr_en) begin
            slot <= wr_data;
        end
    end
endmodule

// File: rtl/xb_rr.sv
module xb_rr #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/xb_pick.sv
module xb_pick #(
    parameter int N = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     hits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
    import xb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_vaddr,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_vaddr,
    input  logic [ADDR_W-1:0] fill_paddr,
    input  logic [1:0]        fill_size,
    input  logic              fill_cacheable,
    input  logic              fill_bufferable,
    input  logic              flush_all,
    input  logic              flush_one,
    input  logic [ADDR_W-1:0] flush_vaddr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_cacheable,
    output logic              rsp_bufferable
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    maint_op_e         op;
    logic              advance;
    logic [ENTRIES-1:0] probe_hit;
    logic [ENTRIES-1:0] flush_hit;
    logic [ENTRIES-1:0] slot_clr;
    logic [ENTRIES-1:0] slot_wr;
    xb_entry_t         slot_q [ENTRIES];
    xb_entry_t         fill_word;
    map_size_e         fill_sz;
    logic [IDX_W-1:0]  victim;
    logic              sel_found;
    logic [IDX_W-1:0]  sel_idx;
    xb_entry_t         sel;

    // Command decode: one command per cycle, fixed priority.
    always_comb begin
        if (flush_all)      op = OP_FLUSH_ALL;
        else if (flush_one) op = OP_FLUSH_ONE;
        else if (fill_en)   op = OP_FILL;
        else                op = OP_NONE;
    end

    always_comb begin
        slot_clr = '0;
        advance  = 1'b0;
        unique case (op)
            OP_FLUSH_ALL: slot_clr = '1;
            OP_FLUSH_ONE: slot_clr = flush_hit;
            OP_FILL:      advance  = 1'b1;
            OP_NONE:      ;
        endcase
    end

    assign fill_sz = map_size_e'(fill_size);

    always_comb begin
        fill_word.size       = fill_sz;
        fill_word.tag        = fill_vaddr & ~offset_mask(fill_sz);
        fill_word.frame      = fill_paddr & ~offset_mask(fill_sz);
        fill_word.cacheable  = fill_cacheable;
        fill_word.bufferable = fill_bufferable;
    end

    xb_rr #(.ENTRIES(ENTRIES)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (advance),
        .ptr   (victim)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign slot_wr[g] = advance && (victim == IDX_W'(g));
        xb_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (slot_wr[g]),
            .wr_data   (fill_word),
            .clr       (slot_clr[g]),
            .probe_va  (lk_vaddr),
            .flush_va  (flush_vaddr),
            .slot      (slot_q[g]),
            .probe_hit (probe_hit[g]),
            .flush_hit (flush_hit[g])
        );
    end

    xb_pick #(.N(ENTRIES)) u_pick (
        .hits  (probe_hit),
        .found (sel_found),
        .idx   (sel_idx)
    );

    assign sel = slot_q[sel_idx];

    // Registered lookup response.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_paddr      <= '0;
            rsp_cacheable  <= 1'b0;
            rsp_bufferable <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid && sel_found) begin
                rsp_hit        <= 1'b1;
                rsp_paddr      <= sel.frame | (lk_vaddr & offset_mask(sel.size));
                rsp_cacheable  <= sel.cacheable;
                rsp_bufferable <= sel.bufferable;
            end else begin
                rsp_hit        <= 1'b0;
                rsp_paddr      <= '0;
                rsp_cacheable  <= 1'b0;
                rsp_bufferable <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/xb_chk.sv
module xb_chk
    import xb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [SPG_OFS-1:0] lk_low,
    input logic               fill_en,
    input logic               flush_all,
    input logic               flush_one,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [ADDR_W-1:0]  rsp_paddr,
    input logic               rsp_cacheable,
    input logic               rsp_bufferable,
    input logic [IDX_W-1:0]   victim
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic fill_taken;
    logic wiped_q;

    assign fill_taken = fill_en && !flush_all && !flush_one;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wiped_q <= 1'b0;
        else        wiped_q <= flush_all;
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    a_r1_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_paddr == '0 && !rsp_cacheable && !rsp_bufferable));

    a_r4_low_offset: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || rsp_paddr[SPG_OFS-1:0] == $past(lk_low)));

    a_r7_wiped_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (wiped_q && lk_valid) |=> !rsp_hit);

    a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_taken && victim != LAST) |=> victim == IDX_W'($past(victim) + 1'b1));

    a_r6_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_taken && victim == LAST) |=> victim == '0);

    a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_taken |=> $stable(victim));
endmodule

bind xlate_buf xb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid       (lk_valid),
    .lk_low         (lk_vaddr[xb_pkg::SPG_OFS-1:0]),
    .fill_en        (fill_en),
    .flush_all      (flush_all),
    .flush_one      (flush_one),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_paddr      (rsp_paddr),
    .rsp_cacheable  (rsp_cacheable),
    .rsp_bufferable (rsp_bufferable),
    .victim         (victim)
);

// File: tb/xlate_buf_tb.sv
`timescale 1ns/1ps
module xlate_buf_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        fill_en = 1'b0;
    logic [31:0] fill_vaddr = '0;
    logic [31:0] fill_paddr = '0;
    logic [1:0]  fill_size = '0;
    logic        fill_cacheable = 1'b0;
    logic        fill_bufferable = 1'b0;
    logic        flush_all = 1'b0;
    logic        flush_one = 1'b0;
    logic [31:0] flush_vaddr = '0;
    logic        rsp_valid, rsp_hit, rsp_cacheable, rsp_bufferable;
    logic [31:0] rsp_paddr;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xlate_buf u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .fill_en(fill_en), .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr),
        .fill_size(fill_size), .fill_cacheable(fill_cacheable),
        .fill_bufferable(fill_bufferable), .flush_all(flush_all),
        .flush_one(flush_one), .flush_vaddr(flush_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .rsp_cacheable(rsp_cacheable), .rsp_bufferable(rsp_bufferable)
    );

    // Bench model of the slot array.
    logic [1:0]  ms [32];
    logic [31:0] mt [32];
    logic [31:0] mf [32];
    logic        mc [32];
    logic        mb [32];
    int          mptr;
    logic [1:0]  pat_sz [32];

    function automatic logic [31:0] bmask(input logic [1:0] s);
        case (s)
            2'd1:    return 32'h000F_FFFF;
            2'd2:    return 32'h0000_1FFF;
            2'd3:    return 32'h0000_0FFF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] base_of(input int i);
        return 32'(i + 1) << 24;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 32; i++) begin
            ms[i] = 2'd0; mt[i] = '0; mf[i] = '0; mc[i] = 1'b0; mb[i] = 1'b0;
        end
        mptr = 0;
    endtask

    task automatic step(input logic lv, input logic [31:0] lva,
                        input logic fe, input logic [31:0] fva, input logic [31:0] fpa,
                        input logic [1:0] fsz, input logic fc, input logic fb,
                        input logic fa, input logic fo, input logic [31:0] mva,
                        input string req);
        logic        eh;
        logic [31:0] ep;
        logic        ec, eb;
        eh = 1'b0; ep = '0; ec = 1'b0; eb = 1'b0;
        lk_valid = lv; lk_vaddr = lva;
        fill_en = fe; fill_vaddr = fva; fill_paddr = fpa; fill_size = fsz;
        fill_cacheable = fc; fill_bufferable = fb;
        flush_all = fa; flush_one = fo; flush_vaddr = mva;
        if (lv) begin
            for (int i = 0; i < 32; i++) begin
                if (!eh && ms[i] != 2'd0 && ((lva & ~bmask(ms[i])) == mt[i])) begin
                    eh = 1'b1;
                    ep = mf[i] | (lva & bmask(ms[i]));
                    ec = mc[i]; eb = mb[i];
                end
            end
        end
        if (fa) begin
            for (int i = 0; i < 32; i++) ms[i] = 2'd0;
        end else if (fo) begin
            for (int i = 0; i < 32; i++)
                if (ms[i] != 2'd0 && ((mva & ~bmask(ms[i])) == mt[i])) ms[i] = 2'd0;
        end else if (fe) begin
            ms[mptr] = fsz;
            mt[mptr] = fva & ~bmask(fsz);
            mf[mptr] = fpa & ~bmask(fsz);
            mc[mptr] = fc; mb[mptr] = fb;
            mptr = (mptr + 1) % 32;
        end
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0; fill_en = 1'b0; flush_all = 1'b0; flush_one = 1'b0;
        nvec++;
        if (rsp_valid !== lv || rsp_hit !== eh || rsp_paddr !== ep ||
            rsp_cacheable !== ec || rsp_bufferable !== eb) begin
            nbad++;
            $display("FAIL %s va=%h: got v=%0b h=%0b pa=%h c=%0b b=%0b, expected v=%0b h=%0b pa=%h c=%0b b=%0b",
                     req, lva, rsp_valid, rsp_hit, rsp_paddr, rsp_cacheable, rsp_bufferable,
                     lv, eh, ep, ec, eb);
        end
    endtask

    task automatic look(input logic [31:0] va, input string req);
        step(1'b1, va, 1'b0, '0, '0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0, req);
    endtask

    task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                        input logic c, input logic b, input string req);
        step(1'b0, '0, 1'b1, va, pa, sz, c, b, 1'b0, 1'b0, '0, req);
    endtask

    task automatic fill_pattern(input int k);
        for (int i = 0; i < 32; i++) begin
            pat_sz[i] = 2'(((i + k) % 3) + 1);
            fill(base_of(i) | 32'h0000_05A5,
                 32'h4000_0000 + 32'(i) * 32'h0110_3000 + 32'(k) * 32'h0800_0000 + 32'h777,
                 pat_sz[i], 1'(i), 1'(i >> 1), "R6 refill");
        end
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 32; i++) begin
            logic [31:0] m;
            m = bmask(pat_sz[i]);
            look(base_of(i), req);
            look(base_of(i) + (32'h7FF & m), req);
            look(base_of(i) + m, req);
            look(base_of(i) + m + 32'h1, req);
            look(base_of(i) + (((m >> 1) ^ 32'h123) & m), req);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs idle after reset
        nvec++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_paddr !== 32'h0) begin
            nbad++;
            $display("FAIL R1 reset outputs: got v=%0b h=%0b pa=%h, expected 0 0 0",
                     rsp_valid, rsp_hit, rsp_paddr);
        end
        look(32'h0000_0000, "R1 empty");
        look(32'h0100_0000, "R1 empty");
        look(32'hFFFF_F123, "R1 empty");

        // R3 R4 R5: fill all slots with mixed sizes, sweep offsets
        fill_pattern(0);
        sweep("R3/R4/R5 pattern0");

        // R6: 33rd refill lands in slot 0
        fill(32'hE000_0000, 32'h1234_5000, 2'd3, 1'b1, 1'b1, "R6 wrap");
        look(base_of(0), "R6 slot0 overwritten");
        look(base_of(1), "R6 slot1 kept");
        look(32'hE000_0ABC, "R6 new slot0");

        // R9: overlapping mappings, lowest index wins
        fill(32'h7700_0000, 32'h2200_0000, 2'd1, 1'b1, 1'b0, "R9 big low");
        fill(32'h7700_0000, 32'h3300_0000, 2'd3, 1'b0, 1'b1, "R9 small high");
        look(32'h7700_0456, "R9 lowest wins seg");
        fill(32'h7800_0000, 32'h4400_0000, 2'd3, 1'b0, 1'b1, "R9 small low");
        fill(32'h7800_0000, 32'h5500_0000, 2'd1, 1'b1, 1'b0, "R9 big high");
        look(32'h7800_0010, "R9 lowest wins page");
        look(32'h7800_5000, "R9 fallback to seg");

        // R8: flush-one removes all covering slots, keeps others
        step(1'b0, '0, 1'b0, '0, '0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h7700_0FFF, "R8 flush overlap");
        look(32'h7700_0456, "R8 both removed");
        look(32'h7800_0010, "R8 neighbour kept");
        step(1'b0, '0, 1'b0, '0, '0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, base_of(10) + 32'h10, "R8 flush one");
        sweep("R8 after flush-one");

        // R3: size code 00 yields an empty slot
        fill(32'hD000_0000, 32'h6600_0000, 2'd0, 1'b1, 1'b1, "R3 code00");
        look(32'hD000_0000, "R3 code00 miss");

        // R11: lookup alongside commands sees old contents
        step(1'b1, 32'hC100_0040, 1'b1, 32'hC100_0000, 32'h0ABC_D000, 2'd3, 1'b1, 1'b0,
             1'b0, 1'b0, '0, "R11 fill same cycle");
        look(32'hC100_0040, "R11 fill visible next");
        step(1'b1, 32'hC100_0080, 1'b0, '0, '0, 2'd0, 1'b0, 1'b0,
             1'b0, 1'b1, 32'hC100_0000, "R11 flush-one same cycle");
        look(32'hC100_0080, "R11 flush-one visible next");

        // R10: priority between commands
        step(1'b0, '0, 1'b1, 32'hC200_0000, 32'h0BBB_0000, 2'd2, 1'b0, 1'b1,
             1'b0, 1'b1, base_of(12), "R10 flush-one beats fill");
        look(32'hC200_0000, "R10 fill ignored");
        look(base_of(12), "R10 flush-one done");
        step(1'b1, base_of(13), 1'b1, 32'hC300_0000, 32'h0CCC_0000, 2'd1, 1'b1, 1'b1,
             1'b1, 1'b1, base_of(14), "R11 R10 flush-all same cycle");
        look(32'hC300_0000, "R10 fill ignored under flush-all");

        // R7: everything gone
        sweep("R7 after flush-all");

        // second pattern, pointer continues from its held value
        fill_pattern(1);
        sweep("R3/R4/R5 pattern1");
        fill_pattern(2);
        sweep("R3/R4/R5 pattern2");
        look(32'h0000_0000, "R2 lookup");
        step(1'b0, 32'h0100_0000, 1'b0, '0, '0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R2 no lookup");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule